// File: doc/BRIEF.md
# Watchdog and Switch-Off Supervisor

This block keeps a power-hold output high while a host controller shows it is alive, and drops that output when the host goes silent or a switch-off is requested. One counter does both jobs. It advances on a slow external tick and reaches its terminal value after eight seconds' worth of ticks. In the watchdog role, every host read of the control/status register sends the counter back to zero. A debounced on-key or low-voltage request moves the counter into the off-timer role. In that role, host reads no longer restart it, and only a stop write carrying a fixed key value can return the block to the watchdog role.

The host uses a small strobe-based register interface. A read strobe returns the status byte and clears the interrupt flag. A control write can request an immediate software switch-off. A stop write cancels a running off-countdown. Two mode pins choose whether the watchdog counts. The tick rate is a parameter, so a short configuration can stand in for the real eight-second window.

Top module: `pwrsup_top`

## Requirements
- R1: After a synchronous active-low reset, power_hold_o is 1, irq_o is 0 and the status byte reads 8'h04.
- R2: With both mode pins low and no reads, power_hold_o falls on the tick that makes TIMEOUT_SEC*TICKS_PER_SEC ticks counted since reset. It is still 1 after one tick fewer.
- R3: In the watchdog role, a read strobe clears the count. Expiry then needs the full terminal number of further ticks.
- R4: In the watchdog role, the counter advances only when both mode pins are 0. Mode values 01, 10 and 11 stop it from counting.
- R5: The on-key line held high for TICKS_PER_SEC consecutive ticks raises a switch-off request. The request enters the off-timer role with the count cleared. In that role, read strobes do not restart the count, and expiry follows the full terminal number of ticks whatever the mode pins are.
- R6: The low-voltage line raises a switch-off request after TICKS_PER_SEC/16 consecutive ticks high. A drop to low before that point restarts its debounce.
- R7: A control write with bit 0 set drops power_hold_o at the next clock edge, but only in the off-timer role. In the watchdog role it has no effect.
- R8: A stop write of 8'hA5 in the off-timer role returns the block to the watchdog role and keeps the accumulated count. A stop write of any other value leaves the role unchanged.
- R9: After a valid stop, a request line that is still high is recognised again only after its full debounce period has passed once more.
- R10: Once power_hold_o is 0, it stays 0 until reset, whatever the bus, request lines or ticks do.
- R11: irq_o is set by each switch-off request and stays set until a read strobe clears it. A read in the same cycle returns it still set.
- R12: The status byte has irq in bit 0, the role in bit 1 (1 means off-timer) and power_hold in bit 2. The other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle slow time-base pulse |
| mode_a_i | input | 1 | Mode pin A (watchdog counts when both pins are 0) |
| mode_b_i | input | 1 | Mode pin B |
| lowbat_i | input | 1 | Low-voltage request line, active high |
| onkey_i | input | 1 | On-key request line, active high |
| rd_ctl_i | input | 1 | Control/status read strobe |
| wr_ctl_i | input | 1 | Control register write strobe |
| wr_stop_i | input | 1 | Stop register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Status byte |
| irq_o | output | 1 | Sticky switch-off interrupt |
| power_hold_o | output | 1 | Power-hold output, low means switch off |

## Verification
Several properties are checked on every cycle. The power-hold output stays low once it has fallen. The count never passes its terminal value. A watchdog-role read clears the count, while an off-role read leaves it unchanged. A disabled watchdog holds its count. A stop keeps the count, and a wrong key leaves the role unchanged. Other behaviour only the bench scenarios can show: the exact tick on which expiry happens, the debounce lengths, re-recognition of a held line after a stop, and the status byte layout. The bench sweeps all four mode settings and several restart points.

// File: rtl/pwrsup_pkg.sv
// Shared constants and types for the switch-off supervisor.
// Assumes the consumers decode the status and control fields by these positions.
package pwrsup_pkg;
    localparam logic [7:0] STOP_KEY  = 8'hA5;
    localparam int         ST_IRQ    = 0;
    localparam int         ST_ROLE   = 1;
    localparam int         ST_HOLD   = 2;
    localparam int         CTL_SWOFF = 0;

    typedef enum logic {
        ROLE_WATCH = 1'b0,
        ROLE_OFF   = 1'b1
    } role_e;
endpackage

// File: rtl/pwrsup_req_filter.sv
// Debounces one request line. It counts consecutive ticks with the line high
// and pulses evt_o once on the tick that reaches LIMIT.
// Assumes line_i is already synchronous to clk and LIMIT >= 1.
module pwrsup_req_filter #(
    parameter int LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic line_i,
    input  logic clear_i,
    output logic evt_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count held ticks, saturate at LIMIT, restart on a low line or a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i || !line_i) begin
            cnt_q <= '0;
        end else if (tick_i && cnt_q != CW'(LIMIT)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Fire on the tick that completes the debounce period.
    always_comb begin
        evt_o = tick_i && line_i && (cnt_q == CW'(LIMIT - 1));
    end

    AST_FILT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT)); // R6
    AST_FILT_SINGLE_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !clear_i) |=> !evt_o); // R9
endmodule

// File: rtl/pwrsup_timer.sv
// Shared eight-second counter with two roles: a read-restartable watchdog and
// a non-restartable off-countdown. On expiry or a software-off it drops
// power_hold_o and then holds it low.
// Assumes stop_i is already qualified by the key value and by the off role.
module pwrsup_timer #(
    parameter int TERM = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic wd_en_i,
    input  logic rd_ctl_i,
    input  logic req_evt_i,
    input  logic stop_i,
    input  logic swoff_i,
    output logic off_role_o,
    output logic power_hold_o
);
    import pwrsup_pkg::*;

    localparam int CW = $clog2(TERM + 1);

    role_e         role_q, role_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic          hold_q, hold_n;
    logic          run;

    // Next-state decision for role, count and hold.
    always_comb begin
        role_n = role_q;
        cnt_n  = cnt_q;
        hold_n = hold_q;
        run    = (role_q == ROLE_OFF) || wd_en_i;
        if (hold_q) begin
            if (req_evt_i && role_q == ROLE_WATCH) begin
                role_n = ROLE_OFF;
                cnt_n  = '0;
            end else begin
                if (stop_i) begin
                    role_n = ROLE_WATCH;
                end
                if (role_q == ROLE_WATCH && rd_ctl_i) begin
                    cnt_n = '0;
                end else if (tick_i && run) begin
                    if (cnt_q == CW'(TERM - 1)) begin
                        cnt_n  = CW'(TERM);
                        hold_n = 1'b0;
                    end else begin
                        cnt_n = cnt_q + 1'b1;
                    end
                end
            end
            if (role_q == ROLE_OFF && swoff_i) begin
                hold_n = 1'b0;
            end
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            role_q <= ROLE_WATCH;
            cnt_q  <= '0;
            hold_q <= 1'b1;
        end else begin
            role_q <= role_n;
            cnt_q  <= cnt_n;
            hold_q <= hold_n;
        end
    end

    assign off_role_o   = (role_q == ROLE_OFF);
    assign power_hold_o = hold_q;

    AST_HOLD_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_q |=> !hold_q); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TERM)); // R2
    AST_OFF_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && role_q == ROLE_OFF && rd_ctl_i && !tick_i) |=> cnt_q == $past(cnt_q)); // R5
    AST_WD_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && role_q == ROLE_WATCH && !req_evt_i && rd_ctl_i) |=> cnt_q == '0); // R3
    AST_WD_DISABLED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && role_q == ROLE_WATCH && !wd_en_i && !rd_ctl_i && !req_evt_i) |=> $stable(cnt_q)); // R4
    AST_STOP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && stop_i && !tick_i && !req_evt_i) |=> (cnt_q == $past(cnt_q)) && (role_q == ROLE_WATCH)); // R8
    AST_SWOFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && role_q == ROLE_OFF && swoff_i) |=> !hold_q); // R7
endmodule

// File: rtl/pwrsup_regs.sv
// Host register decode. It qualifies the stop key and the software-off bit,
// keeps the sticky interrupt and assembles the status byte.
// Assumes single-cycle strobes synchronous to clk.
module pwrsup_regs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_ctl_i,
    input  logic       wr_ctl_i,
    input  logic       wr_stop_i,
    input  logic [7:0] wdata_i,
    input  logic       req_evt_i,
    input  logic       off_role_i,
    input  logic       hold_i,
    output logic       stop_o,
    output logic       swoff_o,
    output logic       irq_o,
    output logic [7:0] rdata_o
);
    import pwrsup_pkg::*;

    logic irq_q;

    // Accept a stop only with the key value while the off-countdown runs.
    always_comb begin
        stop_o  = wr_stop_i && (wdata_i == STOP_KEY) && off_role_i;
        swoff_o = wr_ctl_i && wdata_i[CTL_SWOFF];
    end

    // Sticky interrupt: a request sets it, a read clears it, and a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (req_evt_i) begin
            irq_q <= 1'b1;
        end else if (rd_ctl_i) begin
            irq_q <= 1'b0;
        end
    end

    // Status byte assembly.
    always_comb begin
        rdata_o           = '0;
        rdata_o[ST_IRQ]   = irq_q;
        rdata_o[ST_ROLE]  = off_role_i;
        rdata_o[ST_HOLD]  = hold_i;
    end

    assign irq_o = irq_q;

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !rd_ctl_i) |=> irq_q); // R11
    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctl_i && !req_evt_i) |=> !irq_q); // R11
endmodule

// File: rtl/pwrsup_top.sv
// Watchdog and switch-off supervisor top. It builds one request filter per
// line, the shared timer and the register decode.
// Assumes TICKS_PER_SEC is a multiple of 16 and all inputs are synchronous.
module pwrsup_top #(
    parameter int TICKS_PER_SEC = 32,
    parameter int TIMEOUT_SEC   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       mode_a_i,
    input  logic       mode_b_i,
    input  logic       lowbat_i,
    input  logic       onkey_i,
    input  logic       rd_ctl_i,
    input  logic       wr_ctl_i,
    input  logic       wr_stop_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o,
    output logic       irq_o,
    output logic       power_hold_o
);
    import pwrsup_pkg::*;

    localparam int TERM      = TICKS_PER_SEC * TIMEOUT_SEC;
    localparam int KEY_TICKS = TICKS_PER_SEC;
    localparam int LV_TICKS  = TICKS_PER_SEC / 16;
    localparam int NREQ      = 2;

    logic [NREQ-1:0] lines;
    logic [NREQ-1:0] evts;
    logic            req_evt;
    logic            stop_ok;
    logic            swoff;
    logic            off_role;
    logic            hold;
    logic            wd_en;

    // Gather request lines and mode decode.
    always_comb begin
        lines[0] = lowbat_i;
        lines[1] = onkey_i;
        wd_en    = !mode_a_i && !mode_b_i;
        req_evt  = |evts;
    end

    for (genvar g = 0; g < NREQ; g++) begin : g_req
        localparam int LIM = (g == 0) ? LV_TICKS : KEY_TICKS;
        pwrsup_req_filter #(.LIMIT(LIM)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick_i),
            .line_i  (lines[g]),
            .clear_i (stop_ok),
            .evt_o   (evts[g])
        );
    end

    pwrsup_timer #(.TERM(TERM)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick_i),
        .wd_en_i      (wd_en),
        .rd_ctl_i     (rd_ctl_i),
        .req_evt_i    (req_evt),
        .stop_i       (stop_ok),
        .swoff_i      (swoff),
        .off_role_o   (off_role),
        .power_hold_o (hold)
    );

    pwrsup_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_ctl_i   (rd_ctl_i),
        .wr_ctl_i   (wr_ctl_i),
        .wr_stop_i  (wr_stop_i),
        .wdata_i    (wdata_i),
        .req_evt_i  (req_evt),
        .off_role_i (off_role),
        .hold_i     (hold),
        .stop_o     (stop_ok),
        .swoff_o    (swoff),
        .irq_o      (irq_o),
        .rdata_o    (rdata_o)
    );

    assign power_hold_o = hold;

    AST_BAD_KEY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stop_i && wdata_i != STOP_KEY && !req_evt) |=> off_role == $past(off_role)); // R8
    AST_STATUS_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[7:3] == 5'd0); // R12
endmodule

// File: tb/sim_pwrsup_top.sv
// Bench for pwrsup_top. Sweeps modes and restart points on a small tick
// configuration and computes the expected expiry ticks arithmetically.
module sim_pwrsup_top;
    localparam int TPS  = 32;
    localparam int TSEC = 8;
    localparam int TERM = TPS * TSEC;
    localparam int KEYT = TPS;
    localparam int LVT  = TPS / 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, mode_a = 1'b0, mode_b = 1'b0;
    logic       lowbat = 1'b0, onkey = 1'b0;
    logic       rd = 1'b0, wrc = 1'b0, wrs = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq, hold;
    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] st;

    pwrsup_top #(.TICKS_PER_SEC(TPS), .TIMEOUT_SEC(TSEC)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .mode_a_i(mode_a), .mode_b_i(mode_b),
        .lowbat_i(lowbat), .onkey_i(onkey), .rd_ctl_i(rd), .wr_ctl_i(wrc),
        .wr_stop_i(wrs), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
        .power_hold_o(hold)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 0; rd = 0; wrc = 0; wrs = 0; wdata = 0;
        lowbat = 0; onkey = 0; mode_a = 0; mode_b = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic rd_status(output logic [7:0] v);
        @(negedge clk) rd = 1'b1;
        #1 v = rdata;
        @(negedge clk) rd = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk) begin wrc = 1'b1; wdata = v; end
        @(negedge clk) wrc = 1'b0;
    endtask

    task automatic wr_stop(input logic [7:0] v);
        @(negedge clk) begin wrs = 1'b1; wdata = v; end
        @(negedge clk) wrs = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        @(negedge clk);
        check("R1 hold", hold, 1);
        check("R1 irq", irq, 0);
        check("R12 status after reset", rdata, 8'h04);

        // R2 R4 mode sweep
        for (int m = 0; m < 4; m++) begin
            do_reset();
            mode_a = m[0]; mode_b = m[1];
            ticks(TERM - 1);
            check("R2 hold before term", hold, 1);
            ticks(1);
            check("R4 hold vs mode", hold, (m == 0) ? 0 : 1);
        end

        // R3 restart sweep
        for (int k = 1; k < TERM; k += 63) begin
            do_reset();
            ticks(k);
            rd_status(st);
            ticks(TERM - 1);
            check("R3 hold after restart", hold, 1);
            ticks(1);
            check("R3 expiry after restart", hold, 0);
        end

        // R5 R11 on-key request and off-countdown
        do_reset();
        ticks(50);
        onkey = 1'b1;
        ticks(KEYT - 1);
        check("R5 no irq before hold time", irq, 0);
        ticks(1);
        check("R5 irq at hold time", irq, 1);
        mode_a = 1; mode_b = 1;
        rd_status(st);
        check("R11 read sees irq", st[0], 1);
        check("R12 role bit off", st[1], 1);
        check("R11 irq cleared", irq, 0);
        ticks(TERM / 2);
        rd_status(st);
        ticks(TERM - 1 - TERM / 2);
        check("R5 hold before off expiry", hold, 1);
        check("R11 no re-event while held", irq, 0);
        ticks(1);
        check("R5 off expiry ignores reads", hold, 0);
        onkey = 1'b0;

        // R6 low-voltage debounce, with glitch
        do_reset();
        lowbat = 1'b1;
        ticks(LVT - 1);
        @(negedge clk) lowbat = 1'b0;
        @(negedge clk) lowbat = 1'b1;
        ticks(LVT - 1);
        check("R6 glitch restarts debounce", irq, 0);
        ticks(1);
        check("R6 irq after debounce", irq, 1);
        lowbat = 1'b0;

        // R7 software off
        do_reset();
        wr_ctl(8'h01);
        @(negedge clk);
        check("R7 swoff ignored in watchdog role", hold, 1);
        onkey = 1'b1;
        ticks(KEYT);
        onkey = 1'b0;
        wr_ctl(8'h01);
        check("R7 swoff in off role", hold, 0);

        // R8 stop keeps count, bad key ignored
        do_reset();
        ticks(10);
        lowbat = 1'b1;
        ticks(LVT);
        lowbat = 1'b0;
        ticks(20);
        wr_stop(8'h5A);
        rd_status(st);
        check("R8 bad key keeps off role", st[1], 1);
        wr_stop(8'hA5);
        ticks(TERM - 21);
        check("R8 hold before kept-count expiry", hold, 1);
        ticks(1);
        check("R8 count kept across stop", hold, 0);
        rd_status(st);
        check("R8 role back to watchdog", st[1], 0);
        check("R12 status after expiry", st, 8'h00);

        // R9 re-recognition after stop
        do_reset();
        onkey = 1'b1;
        ticks(KEYT);
        rd_status(st);
        check("R9 irq from first press", st[0], 1);
        wr_stop(8'hA5);
        ticks(KEYT - 1);
        check("R9 no irq before new hold time", irq, 0);
        ticks(1);
        check("R9 recognised again", irq, 1);
        onkey = 1'b0;

        // R10 latched low
        do_reset();
        ticks(TERM);
        check("R10 expired", hold, 0);
        wr_stop(8'hA5);
        rd_status(st);
        onkey = 1'b1;
        ticks(KEYT + 3);
        onkey = 1'b0;
        check("R10 stays low", hold, 0);
        do_reset();
        @(negedge clk);
        check("R10 reset restores hold", hold, 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule